// File: doc/BRIEF.md
# Atomic Read-Modify-Write Bus Sequencer

This block carries out one 32-bit atomic memory operation as a locked read-modify-write on a bus. The bus has separate address and data phases. A request carries an operation code, a word address and an operand value. The block reads the addressed word and keeps the returned value in a holding register. It combines that value with the operand in a general-purpose ALU, writes the result back to the same address, and returns the word that was read before the write.

The sequence moves through five numbered phases:

- 0: idle, or read address.
- 1: read data.
- 2: write address.
- 3: write data.
- 4: error.

A bus error response, or a request address whose two low bits are not zero, ends the sequence in phase 4. The block then returns a trap response. A misaligned request never reaches the bus.

Requests and responses use valid/ready handshakes:

- **Request side.** A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only when all of these hold: the sequencer is in phase 0, no response is waiting, and `excl_busy` is low. For an aligned address `req_ready` also follows `bus_aph_ready`, because taking the request and issuing the read address happen in the same cycle. A misaligned request is taken without waiting for the bus.
- **Response side.** A response stays valid, with its data stable, until `rsp_ready` is seen. A new request cannot be taken while a response is waiting.

Top module: `amo_rmw_seq`

## Requirements
- R1: After reset the block is in phase 0, drives no address phase, holds `bus_lock` low and has no response pending.
- R2: Operation codes are 0 swap (writes the operand unchanged), 1 add, 2 xor, 3 and, 4 or. The written word is the function of the loaded word and the operand. Any code above 8 behaves as swap.
- R3: Codes 5 signed min, 6 signed max, 7 unsigned min and 8 unsigned max write whichever of the loaded word and the operand the comparison selects.
- R4: A sequence without errors issues, in this order:
  - a read address phase (`bus_aph_write`=0);
  - its data phase;
  - a write address phase (`bus_aph_write`=1) to the same address;
  - a write data phase, during which `bus_wdata` carries the computed word.
- R5: A sequence without errors responds with `rsp_trap`=0 and with `rsp_rdata` equal to the word loaded before the write.
- R6: The loaded word is taken only on the phase-1 cycle in which `bus_dph_ready` is high. Read data presented on earlier wait cycles has no effect.
- R7: An error response on the read data phase issues no write address phase. The block enters phase 4 for exactly one cycle, responds with `rsp_trap`=1 and `rsp_rdata`=0, and the memory word is left unchanged.
- R8: An error response on the write data phase gives a trap response (`rsp_trap`=1, `rsp_rdata`=0).
- R9: A request whose address bits [1:0] are not 00 starts no bus transfer at all and gives a trap response.
- R10: `req_ready` is low while `excl_busy` is high, while a sequence is in progress, and while a response waits. A response holds its value until `rsp_ready` is high.
- R11: `bus_lock` is high from the read address phase through the end of the write data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle when both are high |
| req_op | input | 4 | Operation code (see R2, R3) |
| req_addr | input | ADDR_W | Byte address of the word |
| req_operand | input | DATA_W | Operand value |
| excl_busy | input | 1 | An earlier exclusive or atomic access is still outstanding |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | DATA_W | Originally loaded word (zero on trap) |
| rsp_trap | output | 1 | Sequence ended in error |
| bus_aph_valid | output | 1 | Address phase request |
| bus_aph_ready | input | 1 | Address phase accepted |
| bus_aph_write | output | 1 | Address phase is a write |
| bus_aph_addr | output | ADDR_W | Address phase address |
| bus_lock | output | 1 | Locked sequence in progress |
| bus_dph_ready | input | 1 | Data phase completes this cycle |
| bus_dph_err | input | 1 | Completing data phase carries an error |
| bus_rdata | input | DATA_W | Read data |
| bus_wdata | output | DATA_W | Write data, valid in phase 3 |

## Verification
All nine operation codes are run against a memory model. The model adds random address-phase stalls and data-phase wait states, and it drives junk read data on wait cycles, so a capture taken too early gives a wrong stored word. The min/max operands include a pair whose top bit is set, so the signed and unsigned variants pick different words, and a pair of equal values. Read errors, write errors and misaligned addresses are injected separately. Each one leaves its own bus event trace and its own memory result, so an error path that issues a stray transfer or writes the memory is told apart from a correct one. Response back-pressure and a raised `excl_busy` check that the request handshake stays closed.

// File: rtl/amo_pkg.sv
package amo_pkg;

  typedef enum logic [3:0] {
    AMO_SWAP = 4'd0,
    AMO_ADD  = 4'd1,
    AMO_XOR  = 4'd2,
    AMO_AND  = 4'd3,
    AMO_OR   = 4'd4,
    AMO_MIN  = 4'd5,
    AMO_MAX  = 4'd6,
    AMO_MINU = 4'd7,
    AMO_MAXU = 4'd8
  } amo_op_e;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_AND, ALU_OR, ALU_XOR, ALU_PASSB,
    ALU_MIN, ALU_MAX, ALU_MINU, ALU_MAXU
  } alu_op_e;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_RDATA = 3'd1,
    PH_WADDR = 3'd2,
    PH_WDATA = 3'd3,
    PH_ERR   = 3'd4
  } phase_e;

  // Atomic opcodes are lowered onto ordinary ALU operations; swap is a
  // passthrough of operand B.
  function automatic alu_op_e amo_to_alu(input logic [3:0] code);
    case (code)
      AMO_ADD:  return ALU_ADD;
      AMO_XOR:  return ALU_XOR;
      AMO_AND:  return ALU_AND;
      AMO_OR:   return ALU_OR;
      AMO_MIN:  return ALU_MIN;
      AMO_MAX:  return ALU_MAX;
      AMO_MINU: return ALU_MINU;
      AMO_MAXU: return ALU_MAXU;
      default:  return ALU_PASSB;
    endcase
  endfunction

endpackage

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic [W-1:0]   result
);

  logic [W:0]   diff;
  logic         is_unsigned;
  logic         lt;
  logic [W-1:0] lesser, greater;

  // One subtractor serves both compares: the borrow gives the unsigned
  // order, the sign of the difference the signed order when signs agree.
  assign diff        = {1'b0, op_a} - {1'b0, op_b};
  assign is_unsigned = (op == ALU_MINU) || (op == ALU_MAXU);
  assign lt = is_unsigned ? diff[W] :
              (op_a[W-1] ^ op_b[W-1]) ? op_a[W-1] : diff[W-1];

  assign lesser  = lt ? op_a : op_b;
  assign greater = lt ? op_b : op_a;

  always_comb begin
    case (op)
      ALU_ADD:   result = op_a + op_b;
      ALU_AND:   result = op_a & op_b;
      ALU_OR:    result = op_a | op_b;
      ALU_XOR:   result = op_a ^ op_b;
      ALU_MIN,
      ALU_MINU:  result = lesser;
      ALU_MAX,
      ALU_MAXU:  result = greater;
      default:   result = op_b;
    endcase
  end

endmodule

// File: rtl/amo_phase_fsm.sv
module amo_phase_fsm
  import amo_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_ok,
  input  logic   start_bad,
  input  logic   aph_ready,
  input  logic   dph_ready,
  input  logic   dph_err,
  output phase_e phase
);

  phase_e phase_nx;

  always_comb begin
    phase_nx = phase;
    case (phase)
      PH_IDLE:  if (start_bad) phase_nx = PH_ERR;
                else if (start_ok) phase_nx = PH_RDATA;
      PH_RDATA: if (dph_ready) phase_nx = dph_err ? PH_ERR : PH_WADDR;
      PH_WADDR: if (aph_ready) phase_nx = PH_WDATA;
      PH_WDATA: if (dph_ready) phase_nx = dph_err ? PH_ERR : PH_IDLE;
      default:  phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nx;
  end

  // R7: the error phase is never reached from the write address phase
  a_r7_err_not_from_waddr: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_ERR |-> $past(phase) != PH_WADDR);

  // R7: the error phase never stalls
  a_r7_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_ERR |=> phase == PH_IDLE);

  // R4: the write address phase only follows a completed read
  a_r4_waddr_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_WADDR |-> ($past(phase) == PH_RDATA || $past(phase) == PH_WADDR));

endmodule

// File: rtl/amo_rmw_seq.sv
module amo_rmw_seq
  import amo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_operand,
  input  logic              excl_busy,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_trap,
  output logic              bus_aph_valid,
  input  logic              bus_aph_ready,
  output logic              bus_aph_write,
  output logic [ADDR_W-1:0] bus_aph_addr,
  output logic              bus_lock,
  input  logic              bus_dph_ready,
  input  logic              bus_dph_err,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] bus_wdata
);

  localparam int ALIGN_W = $clog2(DATA_W / 8);

  phase_e            phase;
  logic              idle_free, misaligned, accept;
  logic [3:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] operand_q, load_q, wdata_q, alu_out;

  // ---------------- request side ----------------
  assign idle_free  = (phase == PH_IDLE) && !rsp_valid && !excl_busy;
  assign misaligned = |req_addr[ALIGN_W-1:0];
  assign req_ready  = idle_free && (misaligned || bus_aph_ready);
  assign accept     = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q      <= '0;
      addr_q    <= '0;
      operand_q <= '0;
    end else if (accept) begin
      op_q      <= req_op;
      addr_q    <= req_addr;
      operand_q <= req_operand;
    end
  end

  a_r10_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    excl_busy |-> !req_ready);

  // ---------------- phase sequence ----------------
  amo_phase_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_ok  (accept && !misaligned),
    .start_bad (accept && misaligned),
    .aph_ready (bus_aph_ready),
    .dph_ready (bus_dph_ready),
    .dph_err   (bus_dph_err),
    .phase     (phase)
  );

  // ---------------- address phase drive ----------------
  assign bus_aph_valid = (phase == PH_WADDR) ||
                         ((phase == PH_IDLE) && req_valid && idle_free && !misaligned);
  assign bus_aph_write = (phase == PH_WADDR);
  assign bus_aph_addr  = (phase == PH_IDLE) ? req_addr : addr_q;
  assign bus_lock      = bus_aph_valid || (phase == PH_RDATA) ||
                         (phase == PH_WADDR) || (phase == PH_WDATA);

  // R9: an address phase never carries a misaligned address
  a_r9_aligned_aph: assert property (@(posedge clk) disable iff (!rst_n)
    bus_aph_valid |-> bus_aph_addr[ALIGN_W-1:0] == '0);

  // ---------------- load capture ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 load_q <= '0;
    else if (phase == PH_RDATA && bus_dph_ready) load_q <= bus_rdata;
  end

  // R6: the holding register moves only on a completed read data phase
  a_r6_capture_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !(phase == PH_RDATA && bus_dph_ready) |=> $stable(load_q));

  // ---------------- modify and write data ----------------
  amo_alu #(.W(DATA_W)) u_alu (
    .op     (amo_to_alu(op_q)),
    .op_a   (load_q),
    .op_b   (operand_q),
    .result (alu_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  wdata_q <= '0;
    else if (phase == PH_WADDR && bus_aph_ready) wdata_q <= alu_out;
  end

  assign bus_wdata = (phase == PH_WDATA) ? wdata_q : '0;

  // ---------------- response ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_trap  <= 1'b0;
    end else if (phase == PH_WDATA && bus_dph_ready && !bus_dph_err) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= load_q;
      rsp_trap  <= 1'b0;
    end else if (phase == PH_ERR) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= '0;
      rsp_trap  <= 1'b1;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R10: a waiting response is held unchanged
  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_trap));

endmodule

// File: tb/amo_rmw_seq_test.sv
`timescale 1ns/1ps
module amo_rmw_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [3:0]  req_op = '0;
  logic [31:0] req_addr = '0, req_operand = '0;
  logic        excl_busy = 1'b0;
  logic        rsp_valid, rsp_ready = 1'b0, rsp_trap;
  logic [31:0] rsp_rdata;
  logic        bus_aph_valid, bus_aph_ready = 1'b0, bus_aph_write, bus_lock;
  logic [31:0] bus_aph_addr, bus_wdata;
  logic        bus_dph_ready = 1'b0, bus_dph_err = 1'b0;
  logic [31:0] bus_rdata = '0;

  always #2.5 clk = ~clk;

  amo_rmw_seq uut (.*);

  int tests = 0, fails = 0;
  logic [31:0] mem [16];
  int  ev_q[$];
  bit  inj_rd = 0, inj_wr = 0;
  logic [31:0] cur_addr;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_op(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    case (op)
      4'd1: return a + b;
      4'd2: return a ^ b;
      4'd3: return a & b;
      4'd4: return a | b;
      4'd5: return ($signed(a) < $signed(b)) ? a : b;
      4'd6: return ($signed(a) < $signed(b)) ? b : a;
      4'd7: return (a < b) ? a : b;
      4'd8: return (a < b) ? b : a;
      default: return b;
    endcase
  endfunction

  // Bus slave: random stalls, wait states, junk data on wait cycles, errors.
  initial begin
    bit hs_prev = 0, hs_wr = 0, dph_on = 0, dph_wr = 0, drove = 0, e;
    logic [31:0] hs_addr = '0, dph_addr = '0;
    int waits = 0;
    forever begin
      @(negedge clk); #0.5;
      if (drove) begin dph_on = 0; drove = 0; end
      if (hs_prev) begin
        dph_on = 1; dph_wr = hs_wr; dph_addr = hs_addr; waits = $urandom % 4;
      end
      bus_dph_ready = 0; bus_dph_err = 0; bus_rdata = $urandom;
      if (dph_on) begin
        check(bus_lock === 1'b1, "R11 lock in data phase", {31'b0, bus_lock}, 32'd1);
        if (waits > 0) waits--;
        else begin
          bus_dph_ready = 1; drove = 1;
          e = dph_wr ? inj_wr : inj_rd;
          bus_dph_err = e;
          if (!dph_wr) begin
            bus_rdata = mem[dph_addr[5:2]];
            ev_q.push_back(2);
          end else begin
            ev_q.push_back(4);
            if (!e) mem[dph_addr[5:2]] = bus_wdata;
          end
        end
      end
      bus_aph_ready = ($urandom % 3) != 0;
      hs_prev = bus_aph_valid & bus_aph_ready;
      hs_wr = bus_aph_write;
      hs_addr = bus_aph_addr;
      if (hs_prev) begin
        ev_q.push_back(bus_aph_write ? 3 : 1);
        check(bus_aph_addr == cur_addr, "R4 address phase address", bus_aph_addr, cur_addr);
      end
    end
  end

  task automatic run_op(input logic [3:0] op, input logic [31:0] addr, input logic [31:0] b,
                        input bit rd_err, input bit wr_err);
    logic [31:0] old, exp_mem, got_d;
    bit mis, got_t, ok;
    int exp_ev[$];
    mis = addr[1:0] != 2'b00;
    old = mem[addr[5:2]];
    if (mis || rd_err || wr_err) exp_mem = old;
    else exp_mem = ref_op(op, old, b);
    if (mis) exp_ev = {};
    else if (rd_err) exp_ev = {1, 2};
    else exp_ev = {1, 2, 3, 4};
    ev_q.delete(); inj_rd = rd_err; inj_wr = wr_err; cur_addr = addr;
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = addr; req_operand = b;
    forever begin #1; if (req_ready) break; @(negedge clk); end
    @(negedge clk);
    req_valid = 0;
    forever begin
      rsp_ready = ($urandom % 3) == 0;
      #1;
      if (rsp_valid && !rsp_ready)
        check(req_ready == 1'b0, "R10 no accept while response waits", {31'b0, req_ready}, 32'd0);
      if (rsp_valid && rsp_ready) begin got_d = rsp_rdata; got_t = rsp_trap; break; end
      @(negedge clk);
    end
    @(negedge clk);
    rsp_ready = 0;
    if (mis) begin
      check(got_t == 1'b1, "R9 misaligned traps", {31'b0, got_t}, 32'd1);
    end else if (rd_err) begin
      check(got_t == 1'b1, "R7 read error traps", {31'b0, got_t}, 32'd1);
      check(got_d == 32'd0, "R7 trap data zero", got_d, 32'd0);
    end else if (wr_err) begin
      check(got_t == 1'b1, "R8 write error traps", {31'b0, got_t}, 32'd1);
      check(got_d == 32'd0, "R8 trap data zero", got_d, 32'd0);
    end else begin
      check(got_t == 1'b0, "R5 no trap", {31'b0, got_t}, 32'd0);
      check(got_d == old, "R5 returns loaded word", got_d, old);
    end
    check(mem[addr[5:2]] == exp_mem, (op >= 5 && op <= 8) ? "R3 stored word" : "R2 stored word",
          mem[addr[5:2]], exp_mem);
    ok = ev_q.size() == exp_ev.size();
    if (ok) foreach (exp_ev[i]) if (ev_q[i] != exp_ev[i]) ok = 0;
    check(ok, mis ? "R9 no bus transfer" : "R4 phase order", ev_q.size(), exp_ev.size());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h1357_9bdf * (i + 1);
    mem[2] = 32'h8000_0000;
    mem[3] = 32'h0000_0005;
    cur_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    // R1: reset state
    check(rsp_valid == 1'b0, "R1 no response", {31'b0, rsp_valid}, 32'd0);
    check(bus_aph_valid == 1'b0, "R1 no address phase", {31'b0, bus_aph_valid}, 32'd0);
    check(bus_lock == 1'b0, "R1 lock low", {31'b0, bus_lock}, 32'd0);
    rst_n = 1;

    // R2: plain operations, R6 via junk data on wait cycles
    run_op(4'd0, 32'h04, 32'hdead_beef, 0, 0);
    run_op(4'd1, 32'h08, 32'h0000_0011, 0, 0);
    run_op(4'd1, 32'h10, 32'hffff_ffff, 0, 0);
    run_op(4'd2, 32'h14, 32'hf0f0_0f0f, 0, 0);
    run_op(4'd3, 32'h18, 32'h00ff_ff00, 0, 0);
    run_op(4'd4, 32'h1c, 32'h8000_0001, 0, 0);
    run_op(4'd12, 32'h20, 32'h1234_5678, 0, 0);
    // R3: signed vs unsigned with top bit set, then equal values
    run_op(4'd5, 32'h08, 32'h0000_0001, 0, 0);
    mem[2] = 32'h8000_0000;
    run_op(4'd6, 32'h08, 32'h0000_0001, 0, 0);
    mem[2] = 32'h8000_0000;
    run_op(4'd7, 32'h08, 32'h0000_0001, 0, 0);
    mem[2] = 32'h8000_0000;
    run_op(4'd8, 32'h08, 32'h0000_0001, 0, 0);
    run_op(4'd5, 32'h0c, 32'h0000_0005, 0, 0);
    run_op(4'd8, 32'h0c, 32'hffff_fffb, 0, 0);
    // R7, R8, R9: error paths, then recovery
    run_op(4'd1, 32'h24, 32'h1, 1, 0);
    run_op(4'd1, 32'h24, 32'h1, 0, 1);
    run_op(4'd0, 32'h26, 32'h5555_5555, 0, 0);
    run_op(4'd0, 32'h29, 32'h5555_5555, 0, 0);
    run_op(4'd1, 32'h24, 32'h1, 0, 0);
    // R10: excl_busy blocks the request handshake
    @(negedge clk);
    ev_q.delete();
    excl_busy = 1; req_valid = 1; req_op = 4'd0; req_addr = 32'h30; req_operand = 32'h0;
    for (int k = 0; k < 4; k++) begin
      #1;
      check(req_ready == 1'b0, "R10 excl_busy blocks", {31'b0, req_ready}, 32'd0);
      @(negedge clk);
    end
    req_valid = 0; excl_busy = 0;
    check(ev_q.size() == 0, "R10 no transfer while busy", ev_q.size(), 0);
    run_op(4'd1, 32'h30, 32'h7, 0, 0);
    // randomized mix
    for (int n = 0; n < 40; n++)
      run_op(4'($urandom % 9), {26'b0, 4'($urandom % 16), 2'b00}, $urandom,
             ($urandom % 8) == 0, ($urandom % 8) == 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule